// File: doc/BRIEF.md
# Cascadable Content-Addressable Memory with Validity Flags

This block is a small binary content-addressable memory. Every entry holds a 32-bit word and one validity bit. On the port side that validity bit is active low. One operation is issued per clock cycle. A write stores a word and its validity at an address. A read returns the word and validity at an address. A compare presents a search key to all valid entries at once and reports whether any entry holds the key. When it does, it also reports the lowest-numbered entry that holds it.

Several instances can be stacked with a fixed priority order. Each device takes an active-low match input from the device above and drives an active-low match flag to the device below. It does the same with the full indication. Only the device that found the key while no higher device reported a match is allowed to drive the shared result address bus. The external bus protocol and any masking are handled elsewhere.

Top module: `cam_cascade_top`

## Requirements
- R1: A write (op_code 2'b01) stores op_data at op_addr. The entry becomes valid when valid_in_n is 0 and empty when valid_in_n is 1.
- R2: A read (op_code 2'b10) registers the entry's word on rd_data and its validity on rd_valid_n (0 = valid). Both appear after the clock edge that samples the read.
- R3: A compare (op_code 2'b11) uses op_data as the key. After the sampling edge, match_n is 0 and res_addr is the entry index if a valid entry equals the key.
- R4: Empty entries never match. When no valid entry equals the key, match_n is 1 (given cas_match_in_n = 1), res_addr is 0 and res_drive is 0.
- R5: When cas_match_in_n is 0 during a compare, match_n becomes 0 whether or not a local entry matches.
- R6: After a compare, res_drive is 1 only when a local entry matched and cas_match_in_n was 1.
- R7: match_n changes only on a compare. After a read or a write it keeps its value. In that case res_addr shows the accessed address and res_drive is 1.
- R8: full_n is 0 only while every local entry is valid and cas_full_in_n is 0. It is 1 whenever any entry is empty. It follows its inputs without a clock delay.
- R9: Reset (rst_n low) marks every entry empty and clears every stored word to 0. It sets match_n to 1, res_drive to 0, res_addr to 0 and rd_valid_n to 1. After reset no compare can match.
- R10: When several valid entries equal the key, res_addr reports the lowest index.
- R11: op_code 2'b00 is idle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 2 | 00 idle, 01 write, 10 read, 11 compare |
| op_addr | input | ADDR_W (4) | Entry address for read and write |
| op_data | input | DATA_W (32) | Write word or compare key |
| valid_in_n | input | 1 | Validity to write, 0 = valid |
| cas_match_in_n | input | 1 | Match flag from the higher-priority device, tied 1 at the top of the chain |
| cas_full_in_n | input | 1 | Full flag from the adjacent device in the chain |
| rd_data | output | DATA_W (32) | Word returned by the last read |
| rd_valid_n | output | 1 | Validity returned by the last read, 0 = valid |
| res_addr | output | ADDR_W (4) | Match index or access address |
| res_drive | output | 1 | This device owns the shared result bus |
| match_n | output | 1 | Cascaded match flag, active low |
| full_n | output | 1 | Cascaded full flag, active low |

## Verification
Compares are run against a key held by two valid entries, which tells lowest-index priority apart from any other pick. They are also run against a key present only in an empty entry, which separates validity gating from raw data equality, and against a key present nowhere. Each is repeated with the cascade match input low, to separate the forced flag from bus ownership. Reads and writes after a compare show whether the match flag holds while the result address moves. Filling every entry and then toggling the cascade full input and emptying one entry covers each term of the full condition. A reset in mid-run is followed by a compare against the cleared word, which shows that reset empties entries rather than only clearing data.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_CMP   = 2'b11
    } cam_op_e;

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [DATA_W-1:0]             wr_word,
    input  logic                          wr_valid,
    output logic [DATA_W-1:0]             rd_word,
    output logic                          rd_valid,
    output logic [DEPTH-1:0][DATA_W-1:0]  entries,
    output logic [DEPTH-1:0]              valid_vec
);

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;
    logic [DEPTH-1:0]             vld_d, vld_q;

    always_comb begin
        mem_d = mem_q;
        vld_d = vld_q;
        if (wr_en) begin
            mem_d[acc_addr] = wr_word;
            vld_d[acc_addr] = wr_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            vld_q <= '0;
        end else begin
            mem_q <= mem_d;
            vld_q <= vld_d;
        end
    end

    assign rd_word   = mem_q[acc_addr];
    assign rd_valid  = vld_q[acc_addr];
    assign entries   = mem_q;
    assign valid_vec = vld_q;

    // R1 / R4: an empty write leaves that entry unable to match
    a_r4_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !vld_q[$past(acc_addr)]);

    // R1: a stored word is readable at its address on the next cycle
    a_r1_word_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(acc_addr)] == $past(wr_word)));

endmodule

// File: rtl/cam_match.sv
module cam_match #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] entries,
    input  logic [DEPTH-1:0]             valid_vec,
    input  logic [DATA_W-1:0]            key,
    output logic                         hit_any,
    output logic [ADDR_W-1:0]            hit_idx
);

    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] below_mask;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (entries[g] == key);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = ADDR_W'(i);
            end
        end
    end

    assign below_mask = (DEPTH'(1) << hit_idx) - DEPTH'(1);

    // R10: the reported index hits and nothing below it does
    always_comb begin
        if (hit_any) begin
            a_r10_lowest_wins: assert (hit_vec[hit_idx] && ((hit_vec & below_mask) == '0));
        end
    end

endmodule

// File: rtl/cam_cascade_top.sv
module cam_cascade_top #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              valid_in_n,
    input  logic              cas_match_in_n,
    input  logic              cas_full_in_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid_n,
    output logic [ADDR_W-1:0] res_addr,
    output logic              res_drive,
    output logic              match_n,
    output logic              full_n
);

    import cam_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid_n;
        logic [ADDR_W-1:0] raddr;
        logic              drive;
        logic              mflag_n;
    } res_t;

    localparam res_t RES_RESET = '{rdata: '0, rvalid_n: 1'b1, raddr: '0,
                                   drive: 1'b0, mflag_n: 1'b1};

    cam_op_e                      op;
    logic                         wr_en;
    logic [DATA_W-1:0]            st_word;
    logic                         st_valid;
    logic [DEPTH-1:0][DATA_W-1:0] entries;
    logic [DEPTH-1:0]             valid_vec;
    logic                         hit_any;
    logic [ADDR_W-1:0]            hit_idx;
    res_t                         res_d, res_q;

    assign op    = cam_op_e'(op_code);
    assign wr_en = (op == OP_WRITE);

    cam_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .acc_addr  (op_addr),
        .wr_word   (op_data),
        .wr_valid  (!valid_in_n),
        .rd_word   (st_word),
        .rd_valid  (st_valid),
        .entries   (entries),
        .valid_vec (valid_vec)
    );

    cam_match #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_match (
        .entries   (entries),
        .valid_vec (valid_vec),
        .key       (op_data),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx)
    );

    always_comb begin
        res_d = res_q;
        unique case (op)
            OP_WRITE: begin
                res_d.raddr = op_addr;
                res_d.drive = 1'b1;
            end
            OP_READ: begin
                res_d.rdata    = st_word;
                res_d.rvalid_n = !st_valid;
                res_d.raddr    = op_addr;
                res_d.drive    = 1'b1;
            end
            OP_CMP: begin
                res_d.mflag_n = !(hit_any || !cas_match_in_n);
                res_d.drive   = hit_any && cas_match_in_n;
                res_d.raddr   = hit_any ? hit_idx : '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_RESET;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_data    = res_q.rdata;
    assign rd_valid_n = res_q.rvalid_n;
    assign res_addr   = res_q.raddr;
    assign res_drive  = res_q.drive;
    assign match_n    = res_q.mflag_n;
    assign full_n     = !((&valid_vec) && !cas_full_in_n);

    // R7: only a compare may move the match flag
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_CMP) |=> $stable(match_n));

    // R5: a low cascade input forces the flag low after a compare
    a_r5_cascade_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP && !cas_match_in_n) |=> (!match_n && !res_drive));

    // R6: after a compare, bus ownership implies a reported match
    a_r6_claim_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |=> (!res_drive || !match_n));

    // R8: writing an empty entry clears the full condition
    a_r8_not_full_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && valid_in_n) |=> full_n);

    // R11: idle leaves the result registers unchanged
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> ($stable(res_addr) && $stable(res_drive) && $stable(rd_data)));

endmodule

// File: tb/test_cam_cascade_top.sv
`timescale 1ns/1ps
module test_cam_cascade_top;

    localparam int DW = 32;
    localparam int DP = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_code = 2'b00;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic          valid_in_n = 1'b1;
    logic          cas_match_in_n = 1'b1;
    logic          cas_full_in_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          rd_valid_n;
    logic [AW-1:0] res_addr;
    logic          res_drive;
    logic          match_n;
    logic          full_n;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cam_cascade_top #(.DATA_W(DW), .DEPTH(DP), .ADDR_W(AW)) i_cam_cascade_top (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .valid_in_n(valid_in_n), .cas_match_in_n(cas_match_in_n),
        .cas_full_in_n(cas_full_in_n), .rd_data(rd_data), .rd_valid_n(rd_valid_n),
        .res_addr(res_addr), .res_drive(res_drive), .match_n(match_n), .full_n(full_n)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          vn;
        logic          min_n;
        logic          chk_rd;
        logic [DW-1:0] exp_rd;
        logic          exp_rvn;
        logic          chk_res;
        logic          exp_mn;
        logic [AW-1:0] exp_addr;
        logic          exp_drv;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R1: write entry 3 valid
        '{4'd1, 2'b01, 4'd3, 32'hCAFE0003, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        // R1: write entry 7 valid with the same word
        '{4'd1, 2'b01, 4'd7, 32'hCAFE0003, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        // R1: write entry 5 empty
        '{4'd1, 2'b01, 4'd5, 32'h12345678, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        // R2: read entry 3
        '{4'd2, 2'b10, 4'd3, 32'h0, 1'b1, 1'b1, 1'b1, 32'hCAFE0003, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        // R1: read entry 5, stored empty
        '{4'd1, 2'b10, 4'd5, 32'h0, 1'b1, 1'b1, 1'b1, 32'h12345678, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        // R10: two hits, lowest index 3
        '{4'd10, 2'b11, 4'd0, 32'hCAFE0003, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        // R4: key only in an empty entry
        '{4'd4, 2'b11, 4'd0, 32'h12345678, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
        // R5: local hit, cascade low, no claim
        '{4'd5, 2'b11, 4'd0, 32'hCAFE0003, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0},
        // R5: no local hit, cascade low
        '{4'd5, 2'b11, 4'd0, 32'h0000DEAD, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        // R6: local hit, cascade high, claims bus
        '{4'd6, 2'b11, 4'd0, 32'hCAFE0003, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        // R7: read keeps the flag, shows address 5
        '{4'd7, 2'b10, 4'd5, 32'h0, 1'b1, 1'b1, 1'b1, 32'h12345678, 1'b1, 1'b1, 1'b0, 4'd5, 1'b1},
        // R7: write entry 3 empty keeps the flag
        '{4'd7, 2'b01, 4'd3, 32'hCAFE0003, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        // R3: only entry 7 still holds the key
        '{4'd3, 2'b11, 4'd0, 32'hCAFE0003, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd7, 1'b1},
        // R4: empty entry 7 as well
        '{4'd4, 2'b01, 4'd7, 32'hCAFE0003, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        // R4: now nothing matches
        '{4'd4, 2'b11, 4'd0, 32'hCAFE0003, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0}
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic vn);
        @(negedge clk);
        op_code = op; op_addr = a; op_data = d; valid_in_n = vn;
        @(posedge clk);
        @(negedge clk);
        op_code = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 full_n", DW'(full_n), 32'd1);
        check("R9 match_n", DW'(match_n), 32'd1);
        check("R9 res_drive", DW'(res_drive), 32'd0);
        check("R9 rd_valid_n", DW'(rd_valid_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            cas_match_in_n = VECS[v].min_n;
            do_op(VECS[v].op, VECS[v].addr, VECS[v].data, VECS[v].vn);
            if (VECS[v].chk_rd) begin
                check($sformatf("R%0d v%0d rd_data", VECS[v].req, v), rd_data, VECS[v].exp_rd);
                check($sformatf("R%0d v%0d rd_valid_n", VECS[v].req, v), DW'(rd_valid_n), DW'(VECS[v].exp_rvn));
            end
            if (VECS[v].chk_res) begin
                check($sformatf("R%0d v%0d match_n", VECS[v].req, v), DW'(match_n), DW'(VECS[v].exp_mn));
                check($sformatf("R%0d v%0d res_addr", VECS[v].req, v), DW'(res_addr), DW'(VECS[v].exp_addr));
                check($sformatf("R%0d v%0d res_drive", VECS[v].req, v), DW'(res_drive), DW'(VECS[v].exp_drv));
            end
        end
        cas_match_in_n = 1'b1;

        // R11: idle cycles change nothing
        do_op(2'b11, 4'd0, 32'h0000BEEF, 1'b1);
        do_op(2'b00, 4'd9, 32'hCAFE0003, 1'b0);
        do_op(2'b00, 4'd9, 32'hCAFE0003, 1'b0);
        check("R11 idle res_addr", DW'(res_addr), 32'd0);
        check("R11 idle match_n", DW'(match_n), 32'd1);
        do_op(2'b10, 4'd9, 32'h0, 1'b1);
        check("R11 idle no write", DW'(rd_valid_n), 32'd1);

        // R8: fill every entry
        for (int i = 0; i < DP; i++) do_op(2'b01, AW'(i), DW'(i + 100), 1'b0);
        cas_full_in_n = 1'b1;
        #1 check("R8 full with cascade high", DW'(full_n), 32'd1);
        cas_full_in_n = 1'b0;
        #1 check("R8 full with cascade low", DW'(full_n), 32'd0);
        do_op(2'b01, 4'd15, 32'd115, 1'b1);
        check("R8 one entry empty", DW'(full_n), 32'd1);
        do_op(2'b01, 4'd15, 32'd115, 1'b0);
        check("R8 refilled", DW'(full_n), 32'd0);

        // R9: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 full_n after reset", DW'(full_n), 32'd1);
        check("R9 match_n after reset", DW'(match_n), 32'd1);
        rst_n = 1'b1;
        do_op(2'b10, 4'd4, 32'h0, 1'b1);
        check("R9 entry empty", DW'(rd_valid_n), 32'd1);
        check("R9 word cleared", rd_data, 32'd0);
        do_op(2'b11, 4'd0, 32'h0, 1'b1);
        check("R9 no match after reset", DW'(match_n), 32'd1);
        check("R9 no claim after reset", DW'(res_drive), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule